// File: doc/BRIEF.md
# Prescaled Timer with Edge-Triggered Input Capture

This block is an 8-bit up-counter driven by a tick source chosen from seven binary divisions of the system clock or from an externally conditioned tick input. Counting is gated by a run bit. In normal mode the count runs from zero up to a programmed compare value. On the tick that finds the count equal to that value, the counter returns to zero and a timer interrupt flag is set, so the period is the compare value plus one ticks.

In capture mode the counter keeps counting and still sets the timer flag on compare matches, but it wraps from 255 to 0 instead of clearing at the compare value. The capture input is synchronised to the system clock and watched for a selectable edge. When that edge arrives, the running count is copied into a capture register, the counter restarts from zero, and an edge interrupt flag is set. Software measures a pulse longer than 255 ticks by programming the compare value to FFh and counting timer-flag events between two captures.

Access is through a small register bus with four addresses. The control register holds run, clear strobe, mode, clock select and edge select. The data address is written to load the compare value; reading it returns the live count in normal mode and the capture register in capture mode. The flag register is cleared by writing ones.

Top module: `tmr_capture_timer`

## Requirements
- R1: After synchronous reset every register reads zero, the timer is stopped, and both interrupt outputs are low.
- R2: Clock select CTRL[5:3] values 0,1,2,3,4,5,6 give one count tick every 2,4,8,32,128,512,2048 system clocks from a free-running divider. Value 7 gives one tick in each cycle in which ext_tick is high.
- R3: While the run bit CTRL[0] is 0, ticks do not change the count.
- R4: In normal mode (CTRL[2]=0), each tick increments the count. A tick that finds the count equal to the compare value sets the count to 0 and sets the timer flag.
- R5: In capture mode (CTRL[2]=1), a tick that finds the count equal to the compare value sets the timer flag, and the count goes on from 255 to 0 by wrapping.
- R6: Edge select CTRL[7:6] encodes 00 = no edge, 01 = falling, 10 = rising, 11 = both. A selected edge sets the edge flag in either mode. With 00, the input has no effect.
- R7: In capture mode, a selected edge copies the count into the capture register and sets the count to 0, and counting resumes from 0. In normal mode an edge changes neither the count nor the capture register.
- R8: If a selected capture edge and a count tick fall in the same cycle, the capture register gets the value before the increment and the count becomes 0.
- R9: A write to address 1 loads the compare value. A read of address 1 returns the count in normal mode and the capture register in capture mode. The compare value is never read back.
- R10: Writing address 0 with bit 1 set clears the count to 0 in that cycle. Bit 1 always reads back as 0.
- R11: The flags at address 2 (bit 0 timer, bit 1 edge) drive tmr_irq and edge_irq. Each flag stays set until a write to address 2 with a 1 in its bit position. A new set event in the same cycle as that clear keeps the flag set.
- R12: A level change on cap_in that forms a selected edge shows on edge_irq after the third rising clock edge that samples the new level, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | Conditioned external count enable, used when clock select is 7 |
| cap_in | input | 1 | Asynchronous capture input |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 data, 2 flags, 3 unused |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| tmr_irq | output | 1 | Timer compare-match flag |
| edge_irq | output | 1 | Capture-edge flag |

## Verification
A wrong counter value shows up on the data read at once in normal mode. In capture mode it appears as a wrong captured value on the first edge that follows. A wrong compare or wrap decision shows on tmr_irq in the cycle after the tick that should or should not have matched. A fault in the synchroniser depth or in the edge decode moves edge_irq away from its third-edge latency, or sets it for an edge that was not selected. Either way it shows within three clocks of the input change. A flag that drops on its own, or a clear that also wipes the other flag, is seen on the interrupt outputs right after the write.

// File: rtl/tmr_cap_pkg.sv
package tmr_cap_pkg;

    // Seven divided-clock choices; select code NUM_DIV picks the external tick
    localparam int unsigned NUM_DIV  = 7;
    localparam logic [2:0]  CSEL_EXT = 3'(NUM_DIV);

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_DATA  = 2'd1,
        ADDR_FLAG  = 2'd2,
        ADDR_SPARE = 2'd3
    } reg_addr_e;

    // Control register layout, MSB first
    typedef struct packed {
        edge_mode_e edge_mode;   // [7:6]
        logic [2:0] clk_sel;     // [5:3]
        logic       cap_mode;    // [2]
        logic       clr_rsvd;    // [1] write strobe, never stored
        logic       run;         // [0]
    } ctrl_t;

    typedef struct packed {
        logic edge_hit;          // [1]
        logic tmr_hit;           // [0]
    } irq_t;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_ZERO,
        CNT_INC,
        CNT_SNAP
    } cnt_op_e;

    // log2 of the division ratio for each divided-clock select code
    function automatic int unsigned div_shift(int unsigned sel);
        case (sel)
            0:       return 1;
            1:       return 2;
            2:       return 3;
            3:       return 5;
            4:       return 7;
            5:       return 9;
            default: return 11;
        endcase
    endfunction

    function automatic logic edge_match(edge_mode_e mode, logic cur, logic prv);
        case (mode)
            EDGE_FALL: return prv & ~cur;
            EDGE_RISE: return cur & ~prv;
            EDGE_ANY:  return cur ^ prv;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_cap_prescaler.sv
module tmr_cap_prescaler
    import tmr_cap_pkg::*;
#(
    parameter int unsigned PRE_W = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] clk_sel,
    input  logic       ext_tick,
    output logic       tick
);

    logic [PRE_W-1:0]   pre_q;
    logic [NUM_DIV:0]   tap;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    // One tap per divided clock: high on the last cycle of each period
    for (genvar g = 0; g < NUM_DIV; g++) begin : g_tap
        localparam int unsigned SH_RAW = div_shift(g);
        localparam int unsigned SH     = (SH_RAW > PRE_W) ? PRE_W : SH_RAW;
        assign tap[g] = &pre_q[SH-1:0];
    end
    assign tap[NUM_DIV] = ext_tick;

    assign tick = tap[clk_sel];

endmodule

// File: rtl/tmr_cap_edge.sv
module tmr_cap_edge
    import tmr_cap_pkg::*;
#(
    parameter int unsigned SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin,
    input  edge_mode_e mode,
    output logic       hit
);

    logic [SYNC_N-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], pin};
            last_q <= sync_q[SYNC_N-1];
        end
    end

    assign hit = edge_match(mode, sync_q[SYNC_N-1], last_q);

endmodule

// File: rtl/tmr_cap_core.sv
module tmr_cap_core
    import tmr_cap_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             cap_mode,
    input  logic             tick,
    input  logic             hit,
    input  logic             clr,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cap_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             match_pulse
);

    logic    at_cmp;
    logic    step_en;
    cnt_op_e op;

    assign at_cmp      = (cnt_q == cmp_q);
    assign step_en     = run & tick;
    assign match_pulse = step_en & at_cmp;

    // Priority: software clear, then capture edge, then count tick
    always_comb begin
        if (clr)                     op = CNT_ZERO;
        else if (cap_mode && hit)    op = CNT_SNAP;
        else if (step_en)            op = (!cap_mode && at_cmp) ? CNT_ZERO : CNT_INC;
        else                         op = CNT_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cap_q <= '0;
            cmp_q <= '0;
        end else begin
            if (cmp_we) cmp_q <= cmp_wdata;
            case (op)
                CNT_ZERO: cnt_q <= '0;
                CNT_INC:  cnt_q <= cnt_q + 1'b1;
                CNT_SNAP: begin
                    cap_q <= cnt_q;
                    cnt_q <= '0;
                end
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/tmr_capture_timer.sv
module tmr_capture_timer
    import tmr_cap_pkg::*;
#(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned PRE_W  = 11,
    parameter int unsigned SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_tick,
    input  logic             cap_in,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             tmr_irq,
    output logic             edge_irq
);

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_d;
    irq_t             flag_q;
    logic             wr_ctrl;
    logic             wr_data;
    logic             wr_flag;
    logic             clr_w;
    logic             tick_w;
    logic             hit_w;
    logic             match_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] cap_w;
    logic [CNT_W-1:0] cmp_w;

    assign wr_ctrl = bus_wr && (reg_addr_e'(bus_addr) == ADDR_CTRL);
    assign wr_data = bus_wr && (reg_addr_e'(bus_addr) == ADDR_DATA);
    assign wr_flag = bus_wr && (reg_addr_e'(bus_addr) == ADDR_FLAG);
    assign clr_w   = wr_ctrl && bus_wdata[1];

    always_comb begin
        ctrl_d          = ctrl_t'(bus_wdata[7:0]);
        ctrl_d.clr_rsvd = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_d;
    end

    tmr_cap_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .clk_sel  (ctrl_q.clk_sel),
        .ext_tick (ext_tick),
        .tick     (tick_w)
    );

    tmr_cap_edge #(.SYNC_N(SYNC_N)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .pin  (cap_in),
        .mode (ctrl_q.edge_mode),
        .hit  (hit_w)
    );

    tmr_cap_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .run         (ctrl_q.run),
        .cap_mode    (ctrl_q.cap_mode),
        .tick        (tick_w),
        .hit         (hit_w),
        .clr         (clr_w),
        .cmp_we      (wr_data),
        .cmp_wdata   (bus_wdata),
        .cnt_q       (cnt_w),
        .cap_q       (cap_w),
        .cmp_q       (cmp_w),
        .match_pulse (match_w)
    );

    // Sticky flags; a set event wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else begin
            flag_q.tmr_hit  <= match_w | (flag_q.tmr_hit  & ~(wr_flag & bus_wdata[0]));
            flag_q.edge_hit <= hit_w   | (flag_q.edge_hit & ~(wr_flag & bus_wdata[1]));
        end
    end

    assign tmr_irq  = flag_q.tmr_hit;
    assign edge_irq = flag_q.edge_hit;

    always_comb begin
        case (reg_addr_e'(bus_addr))
            ADDR_CTRL: bus_rdata = CNT_W'(ctrl_q);
            ADDR_DATA: bus_rdata = ctrl_q.cap_mode ? cap_w : cnt_w;
            ADDR_FLAG: bus_rdata = CNT_W'(flag_q);
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_capture_chk.sv
module tmr_capture_chk
    import tmr_cap_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic             tmr_irq,
    input logic             edge_irq,
    input logic             run,
    input logic             cap_mode,
    input logic             tick,
    input logic             cap_hit,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] cap_q,
    input logic [CNT_W-1:0] cmp_q
);

    logic clr_req;
    logic tmr_clr_req;
    assign clr_req     = bus_wr && (bus_addr == 2'd0) && bus_wdata[1];
    assign tmr_clr_req = bus_wr && (bus_addr == 2'd2) && bus_wdata[0];

    // R1
    a_r1_reset_clean: assert property (@(posedge clk)
        rst |=> (cnt_q == '0 && cap_q == '0 && !tmr_irq && !edge_irq));

    // R3
    a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !(cap_mode && cap_hit) && !clr_req) |=> $stable(cnt_q));

    // R4
    a_r4_wrap_at_compare: assert property (@(posedge clk) disable iff (rst)
        (!cap_mode && run && tick && cnt_q == cmp_q && !clr_req) |=> (cnt_q == '0 && tmr_irq));

    // R6
    a_r6_edge_sets_flag: assert property (@(posedge clk) disable iff (rst)
        cap_hit |=> edge_irq);

    // R7
    a_r7_capture_restarts: assert property (@(posedge clk) disable iff (rst)
        (cap_mode && cap_hit && !clr_req) |=> (cap_q == $past(cnt_q) && cnt_q == '0));

    // R10
    a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> (cnt_q == '0));

    // R11
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (tmr_irq && !tmr_clr_req) |=> tmr_irq);

endmodule

bind tmr_capture_timer tmr_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tmr_irq   (tmr_irq),
    .edge_irq  (edge_irq),
    .run       (ctrl_q.run),
    .cap_mode  (ctrl_q.cap_mode),
    .tick      (tick_w),
    .cap_hit   (hit_w),
    .cnt_q     (cnt_w),
    .cap_q     (cap_w),
    .cmp_q     (cmp_w)
);

// File: tb/tmr_capture_timer_tb_top.sv
module tmr_capture_timer_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_tick = 1'b0;
    logic       cap_in = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd1;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tmr_irq;
    logic       edge_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [7:0] m_cnt, m_cap, m_cmp;
    logic       m_tf, m_ef, ms1, ms2, mlast;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_capture_timer dut_i (
        .clk       (clk),
        .rst       (rst),
        .ext_tick  (ext_tick),
        .cap_in    (cap_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tmr_irq   (tmr_irq),
        .edge_irq  (edge_irq)
    );

    function automatic logic [7:0] ctrl_word(logic [1:0] em, logic [2:0] cs,
                                             logic cap, logic clr, logic run);
        return {em, cs, cap, clr, run};
    endfunction

    function automatic logic bench_edge(logic [1:0] em, logic cur, logic prv);
        case (em)
            2'b01:   return prv && !cur;
            2'b10:   return cur && !prv;
            2'b11:   return cur != prv;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int div_ratio(int sel);
        case (sel)
            0: return 2;
            1: return 4;
            2: return 8;
            3: return 32;
            4: return 128;
            5: return 512;
            default: return 2048;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        ext_tick  = 1'b0;
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr   = 1'b0;
        bus_addr = 2'd1;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 2'd1;
    endtask

    task automatic step(logic t, logic c);
        @(negedge clk);
        ext_tick = t;
        cap_in   = c;
        @(posedge clk);
        #1;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=expired expected=finished");
            report();
        end
    end

    initial begin
        logic [7:0] d, a, b;
        logic [1:0] em_tab [5];
        int         tog_tab [5];
        int         tk_tab [5];
        int         len_tab [5];
        logic       v;

        em_tab  = '{2'b01, 2'b10, 2'b11, 2'b00, 2'b10};
        tog_tab = '{4, 5, 3, 3, 400};
        tk_tab  = '{2, 2, 3, 2, 1};
        len_tab = '{300, 300, 300, 120, 900};
        void'($urandom(32'd2024));

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;

        // R1 reset state
        rd(2'd0, d); chk("R1 ctrl", d, 0);
        rd(2'd1, d); chk("R1 data", d, 0);
        rd(2'd2, d); chk("R1 flags", d, 0);
        chk("R1 tmr_irq", tmr_irq, 0);
        chk("R1 edge_irq", edge_irq, 0);

        // R9 compare is write-only; read shows the count
        wr(2'd1, 8'hAB);
        rd(2'd1, d); chk("R9 compare not read back", d, 0);

        // R3 stopped timer ignores ticks
        wr(2'd0, ctrl_word(2'b00, 3'd7, 1'b0, 1'b0, 1'b0));
        repeat (10) step(1'b1, 1'b0);
        rd(2'd1, d); chk("R3 stopped count", d, 0);
        wr(2'd0, ctrl_word(2'b00, 3'd7, 1'b0, 1'b0, 1'b1));
        repeat (7) step(1'b1, 1'b0);
        rd(2'd1, d); chk("R4 seven ticks", d, 7);
        wr(2'd0, ctrl_word(2'b00, 3'd7, 1'b0, 1'b0, 1'b0));
        repeat (5) step(1'b1, 1'b0);
        rd(2'd1, d); chk("R3 held after stop", d, 7);

        // R10 clear strobe
        wr(2'd0, ctrl_word(2'b00, 3'd7, 1'b0, 1'b1, 1'b1));
        rd(2'd1, d); chk("R10 cleared", d, 0);
        rd(2'd0, d); chk("R10 strobe reads zero", d[1], 0);

        // R4 random ticks in normal mode
        m_cmp = 8'($urandom % 12);
        wr(2'd1, m_cmp);
        wr(2'd2, 8'h03);
        wr(2'd0, ctrl_word(2'b00, 3'd7, 1'b0, 1'b1, 1'b1));
        m_cnt = 0; m_tf = 0;
        for (int i = 0; i < 400; i++) begin
            logic t;
            t = ($urandom % 2) == 0;
            step(t, 1'b0);
            if (t) begin
                if (m_cnt == m_cmp) begin m_cnt = 0; m_tf = 1; end
                else m_cnt = m_cnt + 1;
            end
            rd(2'd1, d); chk("R4 count", d, m_cnt);
            chk("R4 timer flag", tmr_irq, m_tf);
        end

        // R11 write-one-to-clear, each flag separately
        rd(2'd2, d); chk("R11 flag register", d, {6'd0, 1'b0, m_tf});
        wr(2'd2, 8'h02);
        chk("R11 edge clear keeps timer flag", tmr_irq, m_tf);
        wr(2'd2, 8'h01);
        chk("R11 timer flag cleared", tmr_irq, 0);

        // R2 prescaler ratios
        for (int s = 0; s < 7; s++) begin
            int n;
            wr(2'd1, 8'hFF);
            wr(2'd0, ctrl_word(2'b00, 3'(s), 1'b0, 1'b1, 1'b1));
            rd(2'd1, a);
            for (int k = 0; k < 5000; k++) begin
                @(posedge clk); #1;
                rd(2'd1, b);
                if (b != a) break;
            end
            a = b;
            n = 0;
            for (int k = 0; k < 5000; k++) begin
                @(posedge clk); #1;
                n++;
                rd(2'd1, b);
                if (b != a) break;
            end
            chk($sformatf("R2 ratio sel=%0d", s), n, div_ratio(s));
        end
        wr(2'd0, ctrl_word(2'b00, 3'd7, 1'b0, 1'b1, 1'b1));

        // R5 R6 R7 random capture phases
        m_cap = 0;
        for (int p = 0; p < 5; p++) begin
            m_cmp = (p == 4) ? 8'hFF : 8'($urandom % 40);
            wr(2'd1, m_cmp);
            wr(2'd2, 8'h03);
            wr(2'd0, ctrl_word(em_tab[p], 3'd7, 1'b1, 1'b1, 1'b1));
            m_cnt = 0; m_tf = 0; m_ef = 0;
            ms1 = cap_in; ms2 = cap_in; mlast = cap_in;
            for (int i = 0; i < len_tab[p]; i++) begin
                logic t, c, h, mt;
                t = ($urandom % tk_tab[p]) == 0;
                c = (($urandom % tog_tab[p]) == 0) ? !cap_in : cap_in;
                if (i >= len_tab[p] - 4) begin t = 1'b0; c = cap_in; end
                step(t, c);
                h  = bench_edge(em_tab[p], ms2, mlast);
                mt = t && (m_cnt == m_cmp);
                if (h) begin m_cap = m_cnt; m_cnt = 0; m_ef = 1; end
                else if (t) m_cnt = m_cnt + 1;
                if (mt) m_tf = 1;
                mlast = ms2; ms2 = ms1; ms1 = c;
                rd(2'd1, d); chk("R7 capture value", d, m_cap);
                chk("R6 edge flag", edge_irq, m_ef);
                chk("R5 timer flag in capture mode", tmr_irq, m_tf);
            end
        end

        // R8 R12 coincident edge and tick, edge latency
        v = cap_in;
        wr(2'd1, 8'd200);
        wr(2'd2, 8'h03);
        wr(2'd0, ctrl_word(2'b11, 3'd7, 1'b1, 1'b1, 1'b1));
        repeat (5) step(1'b1, v);
        step(1'b0, !v);
        chk("R12 no flag after first edge", edge_irq, 0);
        step(1'b0, !v);
        chk("R12 no flag after second edge", edge_irq, 0);
        step(1'b1, !v);
        chk("R12 flag after third edge", edge_irq, 1);
        rd(2'd1, d); chk("R8 pre-increment captured", d, 5);
        wr(2'd0, ctrl_word(2'b11, 3'd7, 1'b0, 1'b0, 1'b1));
        rd(2'd1, d); chk("R8 count forced to zero", d, 0);
        repeat (3) step(1'b1, !v);
        rd(2'd1, d); chk("R9 normal mode reads count", d, 3);

        // R6 R7 edge in normal mode flags but does not capture
        wr(2'd2, 8'h02);
        chk("R11 edge flag cleared", edge_irq, 0);
        repeat (3) step(1'b0, v);
        chk("R6 edge flag in normal mode", edge_irq, 1);
        rd(2'd1, d); chk("R7 no restart in normal mode", d, 3);
        wr(2'd0, ctrl_word(2'b11, 3'd7, 1'b1, 1'b0, 1'b1));
        rd(2'd1, d); chk("R7 capture register kept", d, 5);

        done = 1'b1;
        report();
    end

endmodule